// File: doc/BRIEF.md
# Dual-Width Multiported Register File

This block is the general data register file of a DSP-style datapath. It holds eight 32-bit words. Any port may treat a word as a whole, or pick its upper or lower 16-bit half, so the same storage also serves as a sixteen-entry file of 16-bit registers. Two read ports and two write ports work together in every clock cycle.

Reads are combinational and see the value the file will hold after the current clock edge. A word written in a cycle therefore reaches a read port in that same cycle, half by half. A half-word read is returned in the low 16 bits of the read bus. Its upper 16 bits are filled with zeros or with copies of the half's top bit, as the port's extension input asks. Half-word writes merge into the stored word. When both write ports aim at the same half, port 1 takes precedence.

Top module: `dual_width_regfile`

## Requirements
- R1: An active-low reset clears every entry of the file to zero.
- R2: Selector encoding: `sel[1]=0` (codes 2'b00 and 2'b01) selects the full word. A full write stores all 32 bits of the write data, and a full read returns all 32 bits of the entry.
- R3: Selector 2'b10 selects the low half and 2'b11 the high half. A half write stores write data bits [15:0] into the selected half and leaves the other half of the entry unchanged.
- R4: A half read with the extension input low returns the selected half in bits [15:0] and zeros in bits [31:16].
- R5: A half read with the extension input high returns the selected half in bits [15:0] and copies of its bit 15 in bits [31:16].
- R6: Two writes to different entries and two reads all take effect in the same clock cycle.
- R7: If both write ports update the same half of the same entry in one cycle, the value from write port 1 is stored.
- R8: Writes from the two ports that touch different halves of the same entry both take effect. This includes a full write on one port combined with a half write on the other.
- R9: A read in the cycle of a write to the same entry returns the newly written data for each half that is written, and the stored data for any half that is not.
- R10: A write port whose enable is low changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all entries |
| rd0_idx | input | 3 | Read port 0 entry index |
| rd0_sel | input | 2 | Read port 0 width/half selector |
| rd0_sext | input | 1 | Read port 0 sign-extend a half read |
| rd0_data | output | 32 | Read port 0 data |
| rd1_idx | input | 3 | Read port 1 entry index |
| rd1_sel | input | 2 | Read port 1 width/half selector |
| rd1_sext | input | 1 | Read port 1 sign-extend a half read |
| rd1_data | output | 32 | Read port 1 data |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_idx | input | 3 | Write port 0 entry index |
| wr0_sel | input | 2 | Write port 0 width/half selector |
| wr0_data | input | 32 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable, wins on a same-half clash |
| wr1_idx | input | 3 | Write port 1 entry index |
| wr1_sel | input | 2 | Write port 1 width/half selector |
| wr1_data | input | 32 | Write port 1 data |

## Verification
The bench builds the file with its default parameters: eight entries of 32 bits. At this size every entry is reachable, so a short vector table can cover all four selector codes on both write ports and both read ports. It can also reach every clash between the write ports: the same half, opposite halves, and a full write against a half write. Half values with the top bit set and clear are read in both extension modes. A reset in the middle of the run confirms that the populated entries return to zero.

// File: rtl/dual_width_regfile.sv
module dual_width_regfile #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_WORDS)-1:0] rd0_idx,
  input  logic [1:0]                   rd0_sel,
  input  logic                         rd0_sext,
  output logic [WORD_W-1:0]            rd0_data,
  input  logic [$clog2(NUM_WORDS)-1:0] rd1_idx,
  input  logic [1:0]                   rd1_sel,
  input  logic                         rd1_sext,
  output logic [WORD_W-1:0]            rd1_data,
  input  logic                         wr0_en,
  input  logic [$clog2(NUM_WORDS)-1:0] wr0_idx,
  input  logic [1:0]                   wr0_sel,
  input  logic [WORD_W-1:0]            wr0_data,
  input  logic                         wr1_en,
  input  logic [$clog2(NUM_WORDS)-1:0] wr1_idx,
  input  logic [1:0]                   wr1_sel,
  input  logic [WORD_W-1:0]            wr1_data
);
  localparam int HALF_W = WORD_W / 2;
  localparam int IDX_W  = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0][HALF_W-1:0] lo_q, hi_q, lo_d, hi_d;

  // a half write always takes its value from the low lane of the data bus
  logic [HALF_W-1:0] wr0_hi_val, wr1_hi_val;
  assign wr0_hi_val = wr0_sel[1] ? wr0_data[HALF_W-1:0] : wr0_data[WORD_W-1:HALF_W];
  assign wr1_hi_val = wr1_sel[1] ? wr1_data[HALF_W-1:0] : wr1_data[WORD_W-1:HALF_W];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_ent
    logic w0_hit, w1_hit, w0_lo, w0_hi, w1_lo, w1_hi;
    assign w0_hit = wr0_en && (wr0_idx == IDX_W'(i));
    assign w1_hit = wr1_en && (wr1_idx == IDX_W'(i));
    assign w0_lo  = w0_hit && (!wr0_sel[1] || !wr0_sel[0]);
    assign w0_hi  = w0_hit && (!wr0_sel[1] ||  wr0_sel[0]);
    assign w1_lo  = w1_hit && (!wr1_sel[1] || !wr1_sel[0]);
    assign w1_hi  = w1_hit && (!wr1_sel[1] ||  wr1_sel[0]);
    assign lo_d[i] = w1_lo ? wr1_data[HALF_W-1:0] : w0_lo ? wr0_data[HALF_W-1:0] : lo_q[i];
    assign hi_d[i] = w1_hi ? wr1_hi_val : w0_hi ? wr0_hi_val : hi_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  function automatic logic [WORD_W-1:0] shape(input logic [HALF_W-1:0] hi,
                                              input logic [HALF_W-1:0] lo,
                                              input logic [1:0] sel,
                                              input logic sext);
    logic [HALF_W-1:0] h;
    h = sel[0] ? hi : lo;
    if (!sel[1]) return {hi, lo};
    return {{HALF_W{sext & h[HALF_W-1]}}, h};
  endfunction

  assign rd0_data = shape(hi_d[rd0_idx], lo_d[rd0_idx], rd0_sel, rd0_sext);
  assign rd1_data = shape(hi_d[rd1_idx], lo_d[rd1_idx], rd1_sel, rd1_sext);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (lo_q == '0 && hi_q == '0));

  assert_low_write_keeps_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && wr0_sel == 2'b10 && !wr1_en) |=> (hi_q == $past(hi_q)));

  assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_sel[1] && !rd0_sext) |-> (rd0_data[WORD_W-1:HALF_W] == '0));

  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_sel[1] && rd1_sext) |-> (rd1_data[WORD_W-1:HALF_W] == {HALF_W{rd1_data[HALF_W-1]}}));

  assert_port1_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && wr1_en && wr0_idx == wr1_idx && !wr1_sel[1] &&
     rd0_idx == wr1_idx && !rd0_sel[1]) |-> (rd0_data == wr1_data));

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && !wr0_sel[1] && !(wr1_en && wr1_idx == wr0_idx) &&
     rd1_idx == wr0_idx && !rd1_sel[1]) |-> (rd1_data == wr0_data));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr0_en && !wr1_en) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: tb/dual_width_regfile_tb_top.sv
module dual_width_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  rd0_idx, rd1_idx, wr0_idx, wr1_idx;
  logic [1:0]  rd0_sel, rd1_sel, wr0_sel, wr1_sel;
  logic        rd0_sext, rd1_sext, wr0_en, wr1_en;
  logic [31:0] rd0_data, rd1_data, wr0_data, wr1_data;

  dual_width_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_sel(rd0_sel), .rd0_sext(rd0_sext), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_sel(rd1_sel), .rd1_sext(rd1_sext), .rd1_data(rd1_data),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_sel(wr0_sel), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_sel(wr1_sel), .wr1_data(wr1_data));

  typedef struct packed {
    logic w0e; logic [2:0] w0i; logic [1:0] w0s; logic [31:0] w0d;
    logic w1e; logic [2:0] w1i; logic [1:0] w1s; logic [31:0] w1d;
    logic [2:0] r0i; logic [1:0] r0s; logic r0x;
    logic [2:0] r1i; logic [1:0] r1s; logic r1x;
    logic [31:0] e0; logic [31:0] e1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,3'd1,2'b00,32'h11112222, 1'b0,3'd0,2'b00,32'h0, 3'd1,2'b00,1'b0, 3'd0,2'b00,1'b0, 32'h11112222, 32'h0},
    '{1'b0,3'd0,2'b00,32'h0, 1'b0,3'd0,2'b00,32'h0, 3'd1,2'b10,1'b0, 3'd1,2'b11,1'b0, 32'h00002222, 32'h00001111},
    '{1'b1,3'd2,2'b00,32'h80017FFE, 1'b1,3'd3,2'b00,32'hCAFEF00D, 3'd1,2'b00,1'b0, 3'd3,2'b00,1'b0, 32'h11112222, 32'hCAFEF00D},
    '{1'b0,3'd0,2'b00,32'h0, 1'b0,3'd0,2'b00,32'h0, 3'd2,2'b11,1'b1, 3'd2,2'b10,1'b1, 32'hFFFF8001, 32'h00007FFE},
    '{1'b1,3'd1,2'b10,32'hDEADABCD, 1'b0,3'd0,2'b00,32'h0, 3'd1,2'b00,1'b0, 3'd3,2'b10,1'b0, 32'h1111ABCD, 32'h0000F00D},
    '{1'b1,3'd4,2'b00,32'hAAAAAAAA, 1'b1,3'd4,2'b00,32'h55555555, 3'd4,2'b00,1'b0, 3'd4,2'b11,1'b0, 32'h55555555, 32'h00005555},
    '{1'b1,3'd5,2'b11,32'h00001234, 1'b1,3'd5,2'b10,32'h00005678, 3'd5,2'b00,1'b0, 3'd5,2'b11,1'b1, 32'h12345678, 32'h00001234},
    '{1'b1,3'd6,2'b00,32'h99998888, 1'b1,3'd6,2'b11,32'h00007777, 3'd6,2'b00,1'b0, 3'd3,2'b01,1'b0, 32'h77778888, 32'hCAFEF00D},
    '{1'b0,3'd1,2'b00,32'hFFFFFFFF, 1'b0,3'd2,2'b00,32'h0, 3'd1,2'b00,1'b0, 3'd2,2'b00,1'b0, 32'h1111ABCD, 32'h80017FFE},
    '{1'b0,3'd0,2'b00,32'h0, 1'b1,3'd0,2'b11,32'h00008000, 3'd0,2'b11,1'b1, 3'd0,2'b00,1'b0, 32'hFFFF8000, 32'h80000000},
    '{1'b0,3'd0,2'b00,32'h0, 1'b0,3'd0,2'b00,32'h0, 3'd7,2'b00,1'b0, 3'd6,2'b10,1'b1, 32'h0, 32'hFFFF8888},
    '{1'b1,3'd7,2'b10,32'h00000042, 1'b1,3'd7,2'b10,32'h00000099, 3'd7,2'b00,1'b0, 3'd5,2'b10,1'b0, 32'h00000099, 32'h00005678}
  };

  string tags [NV];
  int checks = 0;
  int fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr0_en = 1'b0; wr1_en = 1'b0; wr0_idx = '0; wr1_idx = '0;
    wr0_sel = '0; wr1_sel = '0; wr0_data = '0; wr1_data = '0;
    rd0_idx = '0; rd1_idx = '0; rd0_sel = '0; rd1_sel = '0;
    rd0_sext = 1'b0; rd1_sext = 1'b0;
  endtask

  task automatic check_all_zero(input string req);
    for (int k = 0; k < 8; k += 2) begin
      rd0_idx = 3'(k); rd1_idx = 3'(k + 1);
      #1;
      check(req, rd0_data, 32'h0);
      check(req, rd1_data, 32'h0);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tags = '{"R9 R2 full write bypass", "R4 unsigned halves", "R6 dual write dual read",
             "R5 signed halves", "R3 R9 low-half merge", "R7 same-word clash",
             "R8 opposite halves", "R8 R2 full vs half, sel 01", "R10 disabled writes",
             "R5 R9 high-half bypass", "R5 signed low half", "R7 same low-half clash"};
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all_zero("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr0_en = VECS[v].w0e; wr0_idx = VECS[v].w0i; wr0_sel = VECS[v].w0s; wr0_data = VECS[v].w0d;
      wr1_en = VECS[v].w1e; wr1_idx = VECS[v].w1i; wr1_sel = VECS[v].w1s; wr1_data = VECS[v].w1d;
      rd0_idx = VECS[v].r0i; rd0_sel = VECS[v].r0s; rd0_sext = VECS[v].r0x;
      rd1_idx = VECS[v].r1i; rd1_sel = VECS[v].r1s; rd1_sext = VECS[v].r1x;
      #5;
      check({tags[v], " rd0"}, rd0_data, VECS[v].e0);
      check({tags[v], " rd1"}, rd1_data, VECS[v].e1);
    end

    // R3: the high half of entry 1 must still hold its earlier value
    @(negedge clk) idle();
    rd0_idx = 3'd1; rd0_sel = 2'b11; #1;
    check("R3 untouched high half", rd0_data, 32'h00001111);
    // R10: entry 1 and entry 2 unchanged after the disabled writes
    rd1_idx = 3'd2; rd1_sel = 2'b00; #1;
    check("R10 entry 2 kept", rd1_data, 32'h80017FFE);

    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all_zero("R1 mid-run reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule